// File: doc/BRIEF.md
# Saturating Two's-Complement Adder with Condition Flags

This block adds two equal-width operands and a carry-in through a chain of full-adder cells, then optionally clamps the result instead of letting it wrap around. Two inputs choose the behaviour. One selects whether the operands are treated as signed or unsigned. The other selects plain wraparound or saturation. It has no clock or register stage: every output follows the inputs combinationally.

Signed saturation works as follows. An overflowing sum is replaced by the largest positive value when both operands are non-negative. It is replaced by the most negative value when both are negative. Unsigned saturation replaces the result with all ones whenever the addition carries out of the top bit.

Three condition flags go with the result:
- the overflow flag reports the raw overflow of the selected number system;
- the negative flag copies the top bit of the final result;
- the zero flag is set when the final result is all zeros.

The raw carry-out is also available. These outputs suit a DSP datapath that needs bounded arithmetic and status for later branching.

Top module: `clamp_adder`

## Requirements
- R1: With `satEn`=0, `result` equals (opA + opB + carryIn) modulo 2^WIDTH in both number modes.
- R2: `carryOut` equals bit WIDTH of the unsigned sum opA + opB + carryIn in every mode, and saturation does not change it.
- R3: With `signedMode`=1, `ovfFlag` is 1 exactly when the two's-complement sum lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. With `signedMode`=0, `ovfFlag` equals `carryOut`. This holds whatever the value of `satEn`.
- R4: With `satEn`=1 and `signedMode`=1, an overflow with non-negative operands gives `result` = 0 followed by WIDTH-1 ones (0x7F at WIDTH=8).
- R5: With `satEn`=1 and `signedMode`=1, an overflow with negative operands gives `result` = 1 followed by WIDTH-1 zeros (0x80 at WIDTH=8).
- R6: With `satEn`=1 and `signedMode`=0, a carry-out gives `result` = all ones.
- R7: With `satEn`=1 and no overflow in the selected mode, `result` equals the wraparound sum.
- R8: `negFlag` equals bit WIDTH-1 of the final `result`, after saturation.
- R9: `zeroFlag` is 1 exactly when every bit of the final `result` is 0.
- R10: At WIDTH=8, 120 + 26 with carry-in 0 in signed mode gives 0x92 (-110) when wrapping and 0x7F (127) when saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into the least significant cell |
| satEn | input | 1 | 1 = saturate on overflow, 0 = wrap around |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| result | output | WIDTH | Final sum after optional clamping |
| carryOut | output | 1 | Carry out of the most significant cell |
| ovfFlag | output | 1 | Overflow in the selected number system |
| negFlag | output | 1 | Top bit of `result` |
| zeroFlag | output | 1 | `result` is all zeros |

## Verification
Every operand pair at WIDTH=8 is applied. The carry-in and the four combinations of the two mode inputs rotate across the pairs, so each pair is compared against integer arithmetic in some mode. This separates:
- positive overflow from negative overflow;
- carry-out from signed overflow;
- cases where clamping must leave the sum untouched.

A short table of hand-worked vectors pins down specific values. These include the 120 + 26 case, -128 + -128, 0xFF + 1 unsigned, and overflow caused only by the carry-in. Directed cases then check that zero and negative flags follow the clamped value rather than the raw sum.

// File: rtl/clamp_adder_pkg.sv
package clamp_adder_pkg;
  // Strobes from control to datapath: replace the raw sum with a pattern
  typedef struct packed {
    logic forceEn;   // replace the raw sum
    logic msbVal;    // value driven into the top bit
    logic restVal;   // value driven into every lower bit
  } clampCtl_t;
endpackage

// File: rtl/clamp_adder_fa.sv
module clamp_adder_fa (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);
  logic halfSum;
  assign halfSum = aBit ^ bBit;
  assign sBit    = halfSum ^ cIn;
  assign cOut    = (aBit & bBit) | (halfSum & cIn);
endmodule

// File: rtl/clamp_adder_dp.sv
module clamp_adder_dp
  import clamp_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  clampCtl_t        ctl,
  output logic [WIDTH:0]   carryChain,
  output logic [WIDTH-1:0] rawSum,
  output logic [WIDTH-1:0] result,
  output logic             negFlag,
  output logic             zeroFlag
);
  localparam int TOP = WIDTH - 1;

  assign carryChain[0] = carryIn;

  // carry i enters cell i and leaves as carry i+1
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    clamp_adder_fa u_fa (
      .aBit (opA[i]),
      .bBit (opB[i]),
      .cIn  (carryChain[i]),
      .sBit (rawSum[i]),
      .cOut (carryChain[i+1])
    );
  end

  always_comb begin
    if (ctl.forceEn) begin
      result      = {WIDTH{ctl.restVal}};
      result[TOP] = ctl.msbVal;
    end else begin
      result = rawSum;
    end
  end

  assign negFlag  = result[TOP];
  assign zeroFlag = ~|result;

  always_comb begin
    // R9
    zero_flag_chk: assert (zeroFlag == (result == '0))
      else $error("zero flag disagrees with result");
    // R8
    if (!ctl.forceEn) begin
      neg_raw_chk: assert (negFlag == rawSum[TOP])
        else $error("negative flag disagrees with unclamped sum");
    end
  end
endmodule

// File: rtl/clamp_adder_ctl.sv
module clamp_adder_ctl
  import clamp_adder_pkg::*;
(
  input  logic      aSign,
  input  logic      bSign,
  input  logic      sumSign,
  input  logic      carryIntoTop,
  input  logic      carryOutTop,
  input  logic      satEn,
  input  logic      signedMode,
  output logic      ovfFlag,
  output clampCtl_t ctl
);
  logic signedOvf;

  assign signedOvf = carryIntoTop ^ carryOutTop;
  assign ovfFlag   = signedMode ? signedOvf : carryOutTop;

  always_comb begin
    ctl = '0;
    if (satEn && ovfFlag) begin
      ctl.forceEn = 1'b1;
      if (signedMode) begin
        ctl.msbVal  = aSign;   // negative operands clamp low
        ctl.restVal = ~aSign;
      end else begin
        ctl.msbVal  = 1'b1;
        ctl.restVal = 1'b1;
      end
    end
  end

  always_comb begin
    // R3: sign-based view of overflow must match the carry-based view
    if (signedMode) begin
      ovf_sign_chk: assert (ovfFlag == ((aSign == bSign) && (sumSign != aSign)))
        else $error("signed overflow flag mismatch");
    end
    // R4 R5: signed clamp always uses the operand sign
    if (signedMode && ctl.forceEn) begin
      clamp_dir_chk: assert ((aSign == bSign) && (ctl.msbVal == bSign))
        else $error("signed clamp direction wrong");
    end
  end
endmodule

// File: rtl/clamp_adder.sv
module clamp_adder
  import clamp_adder_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             satEn,
  input  logic             signedMode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             ovfFlag,
  output logic             negFlag,
  output logic             zeroFlag
);
  localparam int TOP = WIDTH - 1;

  clampCtl_t          ctl;
  logic [WIDTH:0]     carryChain;
  logic [WIDTH-1:0]   rawSum;

  clamp_adder_ctl u_ctl (
    .aSign        (opA[TOP]),
    .bSign        (opB[TOP]),
    .sumSign      (rawSum[TOP]),
    .carryIntoTop (carryChain[TOP]),
    .carryOutTop  (carryChain[WIDTH]),
    .satEn        (satEn),
    .signedMode   (signedMode),
    .ovfFlag      (ovfFlag),
    .ctl          (ctl)
  );

  clamp_adder_dp #(.WIDTH(WIDTH)) u_dp (
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .ctl        (ctl),
    .carryChain (carryChain),
    .rawSum     (rawSum),
    .result     (result),
    .negFlag    (negFlag),
    .zeroFlag   (zeroFlag)
  );

  assign carryOut = carryChain[WIDTH];

  logic [WIDTH:0] refSum;
  assign refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    // R2
    carry_out_chk: assert (carryOut == refSum[WIDTH])
      else $error("carry-out mismatch");
    // R1 R7
    if (!satEn || !ovfFlag) begin
      wrap_sum_chk: assert (result == refSum[WIDTH-1:0])
        else $error("unclamped sum mismatch");
    end
    // R6
    if (satEn && !signedMode && carryOut) begin
      uns_clamp_chk: assert (result == {WIDTH{1'b1}})
        else $error("unsigned clamp not all ones");
    end
  end
endmodule

// File: tb/clamp_adder_bench.sv
module clamp_adder_bench;
  // Requirement tags exercised here: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [W-1:0] opA, opB, result;
  logic carryIn, satEn, signedMode;
  logic carryOut, ovfFlag, negFlag, zeroFlag;

  int total = 0;
  int bad   = 0;

  clamp_adder #(.WIDTH(W)) u_clamp_adder (
    .opA(opA), .opB(opB), .carryIn(carryIn), .satEn(satEn),
    .signedMode(signedMode), .result(result), .carryOut(carryOut),
    .ovfFlag(ovfFlag), .negFlag(negFlag), .zeroFlag(zeroFlag)
  );

  // {a, b, cin, sat, sgn, expected result}
  localparam logic [26:0] VEC [10] = '{
    {8'd120, 8'd26,  1'b0, 1'b0, 1'b1, 8'h92},  // R10 wrap
    {8'd120, 8'd26,  1'b0, 1'b1, 1'b1, 8'h7F},  // R10 saturate
    {8'h80,  8'h80,  1'b0, 1'b1, 1'b1, 8'h80},  // R5
    {8'h80,  8'h80,  1'b0, 1'b0, 1'b1, 8'h00},  // R1
    {8'hFF,  8'h01,  1'b0, 1'b1, 1'b0, 8'hFF},  // R6
    {8'hFF,  8'h01,  1'b0, 1'b0, 1'b0, 8'h00},  // R1
    {8'h7F,  8'h00,  1'b1, 1'b1, 1'b1, 8'h7F},  // R4 via carry-in
    {8'h80,  8'hFF,  1'b1, 1'b1, 1'b1, 8'h80},  // R7 no overflow
    {8'h10,  8'h20,  1'b0, 1'b1, 1'b0, 8'h30},  // R7 unsigned
    {8'hFF,  8'hFF,  1'b1, 1'b1, 1'b1, 8'hFF}   // R7 signed -1 + -1 + 1
  };

  task automatic checkVal(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%0d sat=%0d sgn=%0d actual=%0h expected=%0h",
               tag, opA, opB, carryIn, satEn, signedMode, act, exp);
    end
  endtask

  // Full reference check of all outputs against integer arithmetic
  task automatic checkAll();
    int uSum, sSum, expRes, expOvf, expCarry;
    uSum = int'(opA) + int'(opB) + int'(carryIn);
    sSum = int'($signed(opA)) + int'($signed(opB)) + int'(carryIn);
    expCarry = (uSum >> W) & 1;
    expOvf = signedMode ? int'(sSum > 127 || sSum < -128) : expCarry;
    expRes = uSum & 8'hFF;
    if (satEn && expOvf != 0) begin
      if (!signedMode)   expRes = 8'hFF;   // R6
      else if (sSum > 0) expRes = 8'h7F;   // R4
      else               expRes = 8'h80;   // R5
    end
    total++;
    if (result !== expRes[W-1:0] || carryOut !== expCarry[0] ||
        ovfFlag !== expOvf[0] || negFlag !== expRes[W-1] ||
        zeroFlag !== (expRes == 0)) begin
      bad++;
      $display("FAIL R1/R2/R3/R4/R5/R6/R7/R8/R9 a=%h b=%h cin=%0d sat=%0d sgn=%0d actual=%h/%b%b%b%b expected=%h/%b%b%b%b",
               opA, opB, carryIn, satEn, signedMode,
               result, carryOut, ovfFlag, negFlag, zeroFlag,
               expRes[W-1:0], expCarry[0], expOvf[0], expRes[W-1], expRes == 0);
    end
  endtask

  initial begin
    opA = '0; opB = '0; carryIn = 0; satEn = 0; signedMode = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    // idle state: all-zero inputs give zero result, zero flag set (R9)
    checkVal("R9 idle result", int'(result), 0);
    checkVal("R9 idle zero", int'(zeroFlag), 1);

    // hand-worked table (R10, R4, R5, R6, R7)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {opA, opB, carryIn, satEn, signedMode} = VEC[i][26:8];
      #1;
      checkVal("R10 table", int'(result), int'(VEC[i][7:0]));
    end

    // exhaustive operand pairs, rotating modes and carry-in
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        opA = a[7:0]; opB = b[7:0];
        satEn      = ((a + b) % 4) >= 2;
        signedMode = ((a + b) % 2) == 1;
        carryIn    = a[1] ^ b[2];
        #1;
        checkAll();
      end
    end

    // R8 R9: flags follow the clamped value, not the raw sum
    @(negedge clk);
    opA = 8'hFF; opB = 8'h01; carryIn = 0; satEn = 1; signedMode = 0; #1;
    checkVal("R9 zero after clamp", int'(zeroFlag), 0);
    checkVal("R8 neg after clamp", int'(negFlag), 1);
    @(negedge clk);
    opA = 8'h40; opB = 8'h40; carryIn = 0; satEn = 1; signedMode = 1; #1;
    checkVal("R8 neg after signed clamp", int'(negFlag), 0);
    checkVal("R3 ovf with sat", int'(ovfFlag), 1);
    @(negedge clk);
    satEn = 0; #1;
    checkVal("R3 ovf wrap", int'(ovfFlag), 1);
    checkVal("R8 neg wrap", int'(negFlag), 1);
    @(negedge clk);
    opA = 8'h80; opB = 8'h80; carryIn = 0; satEn = 1; signedMode = 0; #1;
    checkVal("R2 carry untouched by clamp", int'(carryOut), 1);
    checkVal("R6 unsigned clamp", int'(result), 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule